// File: doc/BRIEF.md
# Serial Port Register File with Interrupt Logic

This block is the processor-facing side of a classic byte-wide serial port. A host reaches eight byte registers through a 3-bit address with separate read and write strobes. The block holds the baud divisor bytes, the line and modem control bytes and an interrupt enable mask. It turns data writes into a stream of transmit bytes and data reads into consumption of a received byte. It also tracks two interrupt causes: receive data ready and transmitter empty. There is no FIFO, scratch register or loopback. Serialisation and baud timing sit outside the block, so the divisor bytes are only stored and read back.

Pending causes are evaluated again on each clock edge that carries a read or a write strobe. The current interrupt is the highest-numbered pending cause. The interrupt output stays high while any enabled cause is pending. Line status and modem status read back as fixed patterns. The only live bit in them is receive-ready.

Top module: `serial_port_regs`

## Requirements
- R1: Bit 7 of the line control register (address 3) selects the divisor bank. When it is set, address 0 reads and writes the low divisor byte and address 1 the high divisor byte. When it is clear, address 0 is the data port and address 1 is the interrupt enable mask.
- R2: A write to address 0 with bit 7 of line control clear raises txValid for that cycle, with txByte equal to the written byte. It also sets pending cause bit 1 (transmitter empty).
- R3: A read of address 0 with bit 7 of line control clear returns rxByte and pulses rxTake in the same cycle when rxReady is high. When rxReady is low it returns 0 and rxTake stays low.
- R4: On each access, pending bit 0 takes the value of rxReady, or 0 if the byte is consumed by that access. The pending vector is then ANDed with the interrupt enable value in force after the access.
- R5: After an access that leaves the pending vector non-zero, the current interrupt becomes the index of its most significant set bit. After an access that leaves it zero, the current interrupt keeps its previous value.
- R6: A read of address 2 returns the current interrupt shifted left by one, with bit 0 set when nothing is pending. When the current interrupt is 1 (transmitter empty), that read clears pending bit 1.
- R7: Address 5 reads 0x60 ORed with rxReady in bit 0. Address 6 reads 0xB0. Address 7 reads 0x00.
- R8: Addresses 3 and 4 read back the last byte written to them.
- R9: irq is high exactly when the pending vector is non-zero. Pending state and the current interrupt change only on cycles with a read or write strobe.
- R10: After reset all registers, the pending vector and the current interrupt are zero. irq is low and address 2 reads 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regAddr | input | 3 | Register address |
| regWr | input | 1 | Write strobe, one access per cycle |
| regRd | input | 1 | Read strobe, one access per cycle |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid in the cycle of regRd |
| txValid | output | 1 | Transmit byte valid, one cycle per data write |
| txByte | output | 8 | Transmit byte |
| rxByte | input | 8 | Received byte offered by the serial side |
| rxReady | input | 1 | Received byte available |
| rxTake | output | 1 | Received byte consumed this cycle |
| irq | output | 1 | Level interrupt request |

## Verification
Directed sequences check each cause on its own. A data write with only the transmit cause enabled must raise irq, and an identification read then drops it. A ready receive byte with only the receive cause enabled must report index 0. With both causes active, the identification read must report index 1 first and index 0 after that, which separates highest-index selection from lowest-index selection. Further directed steps switch the divisor bank on and off, disable a cause while it is pending, and read the status addresses with rxReady both high and low. A long seeded random mix of reads, writes and rxReady levels is then compared against a bench model after every access, and idle cycles are inserted to confirm that nothing changes without a strobe.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;
  localparam int REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] ADR_DATA = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADR_MASK = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADR_IDENT = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADR_LINE = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADR_MODEM = 3'd4;
  localparam logic [REG_ADDR_W-1:0] ADR_LSTAT = 3'd5;
  localparam logic [REG_ADDR_W-1:0] ADR_MSTAT = 3'd6;

  localparam int BANK_BIT = 7;
  localparam int RX_CAUSE = 0;
  localparam int TX_CAUSE = 1;

  typedef struct packed {
    logic                  access;
    logic                  wrDivLo;
    logic                  wrDivHi;
    logic                  wrMask;
    logic                  wrLine;
    logic                  wrModem;
    logic                  txWr;
    logic                  rxRd;
    logic                  identRd;
    logic [REG_ADDR_W-1:0] sel;
  } strobe_t;
endpackage

// File: rtl/serial_port_ctrl.sv
module serial_port_ctrl
  import serial_port_pkg::*;
(
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWr,
  input  logic                  regRd,
  input  logic                  bankSel,
  input  logic                  rxReady,
  output strobe_t               st,
  output logic                  txValid,
  output logic                  rxTake
);
  logic isData, isMask;

  always_comb begin
    isData     = (regAddr == ADR_DATA);
    isMask     = (regAddr == ADR_MASK);
    st         = '0;
    st.sel     = regAddr;
    st.access  = regWr | regRd;
    st.wrDivLo = regWr & isData & bankSel;
    st.wrDivHi = regWr & isMask & bankSel;
    st.wrMask  = regWr & isMask & ~bankSel;
    st.wrLine  = regWr & (regAddr == ADR_LINE);
    st.wrModem = regWr & (regAddr == ADR_MODEM);
    st.txWr    = regWr & isData & ~bankSel;
    st.rxRd    = regRd & isData & ~bankSel;
    st.identRd = regRd & (regAddr == ADR_IDENT);
  end

  assign txValid = st.txWr;
  assign rxTake  = st.rxRd & rxReady;
endmodule

// File: rtl/serial_port_dpath.sv
module serial_port_dpath
  import serial_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] LSTAT_BASE = 8'h60,
  parameter logic [DATA_W-1:0] MSTAT_FIXED = 8'hB0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxReady,
  output logic              bankSel,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  localparam int CUR_W = $clog2(DATA_W);

  logic [DATA_W-1:0] divLo, divHi, maskReg, lineReg, modemReg;
  logic [DATA_W-1:0] pend, pendNext, maskNext, pendWork;
  logic [CUR_W-1:0]  cur, curNext;
  logic [DATA_W-1:0] identVal;

  assign bankSel = lineReg[BANK_BIT];

  always_comb begin
    pendWork = pend;
    if (st.txWr) pendWork[TX_CAUSE] = 1'b1;
    if (st.identRd && (cur == CUR_W'(TX_CAUSE))) pendWork[TX_CAUSE] = 1'b0;
    pendWork[RX_CAUSE] = rxReady & ~st.rxRd;
    maskNext = st.wrMask ? wrData : maskReg;
    pendNext = pendWork & maskNext;
    curNext  = cur;
    for (int i = 0; i < DATA_W; i++) begin
      if (pendNext[i]) curNext = CUR_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divLo    <= '0;
      divHi    <= '0;
      maskReg  <= '0;
      lineReg  <= '0;
      modemReg <= '0;
      pend     <= '0;
      cur      <= '0;
    end else begin
      if (st.wrDivLo) divLo <= wrData;
      if (st.wrDivHi) divHi <= wrData;
      if (st.wrLine)  lineReg <= wrData;
      if (st.wrModem) modemReg <= wrData;
      if (st.access) begin
        maskReg <= maskNext;
        pend    <= pendNext;
        cur     <= curNext;
      end
    end
  end

  always_comb begin
    identVal    = '0;
    identVal    = DATA_W'({cur, 1'b0});
    identVal[0] = (pend == '0);
  end

  always_comb begin
    unique case (st.sel)
      ADR_DATA:  rdData = bankSel ? divLo : (rxReady ? rxByte : '0);
      ADR_MASK:  rdData = bankSel ? divHi : maskReg;
      ADR_IDENT: rdData = identVal;
      ADR_LINE:  rdData = lineReg;
      ADR_MODEM: rdData = modemReg;
      ADR_LSTAT: rdData = LSTAT_BASE | DATA_W'(rxReady);
      ADR_MSTAT: rdData = MSTAT_FIXED;
      default:   rdData = '0;
    endcase
  end

  assign irq = |pend;

  AST_PEND_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~maskReg) == '0); // R4
  AST_TX_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (st.txWr && maskReg[TX_CAUSE]) |=> irq); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !st.access |=> ($stable(pend) && $stable(cur))); // R9
  AST_IDENT_CLEARS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (st.identRd && cur == CUR_W'(TX_CAUSE)) |=> !pend[TX_CAUSE]); // R6
  AST_RX_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (st.rxRd && !st.wrMask) |=> !pend[RX_CAUSE]); // R3
endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
  import serial_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWr,
  input  logic                  regRd,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  output logic                  txValid,
  output logic [DATA_W-1:0]     txByte,
  input  logic [DATA_W-1:0]     rxByte,
  input  logic                  rxReady,
  output logic                  rxTake,
  output logic                  irq
);
  strobe_t st;
  logic    bankSel;

  serial_port_ctrl u_ctrl (
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .bankSel(bankSel),
    .rxReady(rxReady), .st(st), .txValid(txValid), .rxTake(rxTake)
  );

  serial_port_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .st(st), .wrData(wrData), .rxByte(rxByte),
    .rxReady(rxReady), .bankSel(bankSel), .rdData(rdData), .irq(irq)
  );

  assign txByte = wrData;
endmodule

// File: tb/tb_serial_port_regs.sv
module tb_serial_port_regs;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] regAddr = '0;
  logic       regWr = 1'b0, regRd = 1'b0;
  logic [7:0] wrData = '0, rxByte = '0;
  logic       rxReady = 1'b0;
  logic [7:0] rdData, txByte;
  logic       txValid, rxTake, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] mDivLo, mDivHi, mMask, mLine, mModem, mPend;
  int mCur;

  serial_port_regs dut (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .wrData(wrData), .rdData(rdData), .txValid(txValid), .txByte(txByte),
    .rxByte(rxByte), .rxReady(rxReady), .rxTake(rxTake), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic int topBit(input logic [7:0] v);
    int r = 0;
    for (int i = 0; i < 8; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic logic [7:0] expRead(input logic [2:0] a, input bit rdy, input logic [7:0] rb);
    bit bank = mLine[7];
    case (a)
      3'd0: return bank ? mDivLo : (rdy ? rb : 8'h00);
      3'd1: return bank ? mDivHi : mMask;
      3'd2: return 8'((mCur << 1) | ((mPend == 0) ? 1 : 0));
      3'd3: return mLine;
      3'd4: return mModem;
      3'd5: return 8'h60 | {7'd0, rdy};
      3'd6: return 8'hB0;
      default: return 8'h00;
    endcase
  endfunction

  task automatic modelUpdate(input bit isWr, input logic [2:0] a, input logic [7:0] d,
                             input bit rdy, input bit take);
    bit bank = mLine[7];
    logic [7:0] p = mPend;
    logic [7:0] maskN = mMask;
    if (isWr && a == 0 && !bank) p[1] = 1'b1;
    if (!isWr && a == 2 && mCur == 1) p[1] = 1'b0;
    p[0] = rdy && !take;
    if (isWr && a == 1 && !bank) maskN = d;
    p = p & maskN;
    if (p != 0) mCur = topBit(p);
    mPend = p;
    mMask = maskN;
    if (isWr) begin
      if (a == 0 && bank) mDivLo = d;
      if (a == 1 && bank) mDivHi = d;
      if (a == 3) mLine = d;
      if (a == 4) mModem = d;
    end
  endtask

  task automatic access(input bit isWr, input logic [2:0] a, input logic [7:0] d,
                        input bit rdy, input logic [7:0] rb, input string tag);
    bit expTx, expTake;
    regAddr = a; regWr = isWr; regRd = !isWr; wrData = d; rxReady = rdy; rxByte = rb;
    expTx = isWr && a == 0 && !mLine[7];
    expTake = !isWr && a == 0 && !mLine[7] && rdy;
    #(CLK_P/4);
    if (!isWr) check({tag, " read"}, rdData, expRead(a, rdy, rb));
    check("R2 txValid", {7'd0, txValid}, {7'd0, expTx});
    if (expTx) check("R2 txByte", txByte, d);
    check("R3 rxTake", {7'd0, rxTake}, {7'd0, expTake});
    @(posedge clk);
    modelUpdate(isWr, a, d, rdy, expTake);
    @(negedge clk);
    regWr = 1'b0; regRd = 1'b0;
    check({tag, " R9 irq"}, {7'd0, irq}, {7'd0, mPend != 0});
  endtask

  task automatic idle(input bit rdy);
    logic expIrq = irq;
    rxReady = rdy;
    @(posedge clk);
    @(negedge clk);
    check("R9 idle irq", {7'd0, irq}, {7'd0, expIrq});
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    mDivLo = 0; mDivHi = 0; mMask = 0; mLine = 0; mModem = 0; mPend = 0; mCur = 0;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    check("R10 irq", {7'd0, irq}, 8'h00);
    access(0, 3'd2, 0, 0, 0, "R10 ident");
    access(0, 3'd3, 0, 0, 0, "R10 line");
    access(0, 3'd1, 0, 0, 0, "R10 mask");
    // R8 control registers
    access(1, 3'd3, 8'h1B, 0, 0, "R8 wr");
    access(0, 3'd3, 0, 0, 0, "R8 line");
    access(1, 3'd4, 8'h5A, 0, 0, "R8 wr");
    access(0, 3'd4, 0, 0, 0, "R8 modem");
    // R1 divisor bank
    access(1, 3'd3, 8'h83, 0, 0, "R1 bank on");
    access(1, 3'd0, 8'h34, 0, 0, "R1 divlo");
    access(1, 3'd1, 8'h12, 0, 0, "R1 divhi");
    access(0, 3'd0, 0, 1, 8'hEE, "R1 divlo");
    access(0, 3'd1, 0, 0, 0, "R1 divhi");
    access(1, 3'd3, 8'h03, 0, 0, "R1 bank off");
    access(0, 3'd1, 0, 0, 0, "R1 mask");
    // R2 R6 transmit cause
    access(1, 3'd1, 8'h02, 0, 0, "R4 mask tx");
    access(1, 3'd0, 8'hA5, 0, 0, "R2 tx");
    access(0, 3'd2, 0, 0, 0, "R6 ident tx");
    access(0, 3'd2, 0, 0, 0, "R6 ident empty");
    // R4 masked receive cause
    access(0, 3'd3, 0, 1, 0, "R4 rx masked");
    access(1, 3'd1, 8'h01, 1, 0, "R4 mask rx");
    access(0, 3'd2, 0, 1, 0, "R5 ident rx");
    // R5 both causes, highest first
    access(1, 3'd1, 8'h03, 1, 0, "R5 mask both");
    access(1, 3'd0, 8'h3C, 1, 0, "R5 tx");
    access(0, 3'd2, 0, 1, 0, "R5 ident high");
    access(0, 3'd2, 0, 1, 0, "R5 ident low");
    // R3 consume
    access(0, 3'd0, 0, 1, 8'h77, "R3 rx data");
    access(0, 3'd0, 0, 0, 8'h77, "R3 rx none");
    access(1, 3'd1, 8'h02, 0, 0, "R4 mask");
    access(1, 3'd0, 8'h11, 0, 0, "R2 tx");
    access(1, 3'd1, 8'h00, 0, 0, "R4 disable pending");
    access(0, 3'd2, 0, 0, 0, "R5 cur held");
    // R7 status
    access(0, 3'd5, 0, 1, 0, "R7 lstat");
    access(0, 3'd5, 0, 0, 0, "R7 lstat");
    access(0, 3'd6, 0, 0, 0, "R7 mstat");
    access(0, 3'd7, 0, 1, 0, "R7 addr7");
    // R9 idle
    access(1, 3'd1, 8'h03, 0, 0, "R9 mask");
    access(1, 3'd0, 8'h42, 0, 0, "R9 tx");
    idle(1); idle(0);
    // random mix
    for (int n = 0; n < 1500; n++) begin
      bit isWr = $urandom_range(0, 1);
      logic [2:0] a = 3'($urandom_range(0, 7));
      logic [7:0] d = 8'($urandom);
      if (a == 3 && isWr && $urandom_range(0, 3) != 0) d[7] = 1'b0;
      access(isWr, a, d, 1'($urandom_range(0, 1)), 8'($urandom), "R5 random");
      if ($urandom_range(0, 7) == 0) idle(1'($urandom_range(0, 1)));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule